// File: doc/BRIEF.md
# Timer Event Interrupt Aggregator

This block holds a free-running up-counter and merges everything it and a bank of capture/compare channels report into one interrupt line. Two overflow detectors watch the counter: one for the full-width wrap, and one for a carry out of a selectable group of low bits. Each channel presents a one-cycle event strobe, and the channel logic itself lives outside this block.

Every source latches into its own sticky flag, whether or not that source is enabled. Software clears a flag with a write-one-to-clear strobe. The interrupt line is a registered level. It is high when a global enable and a block enable are both set and at least one flag is set whose own enable is also set.

The low-bit overflow width is one shared select value, because all channels that run narrow PWM use the same cycle length.

Top module: `tmr_irq_agg`

## Requirements
- R1: After reset the count is 0, every flag is 0 and `irq` is 0.
- R2: The count increases by one on a clock edge only when `run_en` and `tick` are both 1 and `load_en` is 0. Otherwise it holds its value, unless it is loaded.
- R3: When `load_en` is 1, the next count is `load_val`, even when the counter would also advance. A load never sets an overflow flag.
- R4: `main_flag` becomes 1 on the same edge on which an advance takes the count from 16'hFFFF to 0.
- R5: `mid_flag` becomes 1 on the edge on which an advance carries out of the low W bits, which means the low W bits were all ones. `mid_sel` picks W: 0 selects 8, 1 selects 9, 2 selects 10, 3 selects 11.
- R6: A 1 on `ch_evt[i]` sets `ch_flag[i]` on that edge and leaves the other channel flags unchanged.
- R7: Flags are set whatever the state of their enables, `blk_en` and `glb_en`.
- R8: A 1 on a clear strobe (`clr_main`, `clr_mid`, `clr_ch[i]`) clears that flag on the next edge. When a set and a clear reach the same flag in the same cycle, the flag ends up at 1.
- R9: `irq` is registered. One edge after the state changes, it equals `glb_en & blk_en & (any flag that is set and has its enable set)`. The enables are `ie_main`, `ie_mid` and `ie_ch[i]`.
- R10: When either `glb_en` or `blk_en` is 0, `irq` is 0 on the next edge. The flags are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counter run enable |
| tick | input | 1 | Count tick qualifier |
| load_en | input | 1 | Synchronous counter load strobe |
| load_val | input | 16 | Value to load |
| mid_sel | input | 2 | Intermediate overflow width select (8 + value) |
| ch_evt | input | 6 | Per-channel event strobes |
| clr_main | input | 1 | Clear strobe for the full overflow flag |
| clr_mid | input | 1 | Clear strobe for the intermediate overflow flag |
| clr_ch | input | 6 | Per-channel flag clear strobes |
| ie_main | input | 1 | Interrupt enable for the full overflow flag |
| ie_mid | input | 1 | Interrupt enable for the intermediate overflow flag |
| ie_ch | input | 6 | Per-channel interrupt enables |
| blk_en | input | 1 | Block interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| count | output | 16 | Current counter value |
| main_flag | output | 1 | Full-width overflow flag |
| mid_flag | output | 1 | Intermediate overflow flag |
| ch_flag | output | 6 | Per-channel event flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The overflow detectors are the hardest part to reach, because a wrap needs many advances. The stimulus uses the load port to place the count one step below each carry point and then gives a single qualified tick. For each width select, it also tries a value one carry below the boundary, which must leave the flag clear. A set and a clear aimed at the same flag in one cycle are forced on a channel flag and on the full overflow flag, the second by timing a clear strobe to the wrapping tick.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    // Width of the low-bit group whose carry sets the intermediate flag.
    typedef enum logic [1:0] {
        MID_W8  = 2'd0,
        MID_W9  = 2'd1,
        MID_W10 = 2'd2,
        MID_W11 = 2'd3
    } mid_sel_e;

    localparam int MID_SEL_N   = 4;
    localparam int SRC_MAIN    = 0;
    localparam int SRC_MID     = 1;
    localparam int SRC_CH_BASE = 2;

endpackage

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MID_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  mid_sel_e         mid_sel,
    output logic [CNT_W-1:0] count_o,
    output logic             full_ovf_o,
    output logic             mid_ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    adv;
    logic    full_ovf;
    logic    mid_ovf;
    logic [MID_SEL_N-1:0] mid_hit;

    // One carry detector per selectable low-bit width.
    for (genvar g = 0; g < MID_SEL_N; g++) begin : g_mid_det
        assign mid_hit[g] = &st_q.cnt[MID_BASE+g-1:0];
    end

    always_comb begin
        st_d     = st_q;
        adv      = run_en & tick & ~load_en;
        full_ovf = adv & (&st_q.cnt);
        mid_ovf  = adv & mid_hit[mid_sel];
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.cnt;
    assign full_ovf_o = full_ovf;
    assign mid_ovf_o  = mid_ovf;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(run_en && tick)) |=> $stable(count_o)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && run_en && tick) |=> (count_o == $past(count_o) + 1'b1)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count_o == $past(load_val))); // R3
    AST_LOAD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (!full_ovf_o && !mid_ovf_o)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        full_ovf_o |=> (count_o == '0)); // R4

endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_o
);

    typedef struct packed {
        logic [NSRC-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (set_i[i]) begin
                st_d.flags[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flags[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0)); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0)); // R6

endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            blk_en,
    input  logic            glb_en,
    output logic            irq_o
);

    typedef struct packed {
        logic irq;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     any_pend;

    always_comb begin
        st_d     = st_q;
        any_pend = |(flags_i & en_i);
        st_d.irq = glb_en & blk_en & any_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(glb_en && blk_en) |=> !irq_o); // R10
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & en_i) == '0) |=> !irq_o); // R9

endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_CH   = 6,
    parameter int MID_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [1:0]        mid_sel,
    input  logic [NUM_CH-1:0] ch_evt,
    input  logic              clr_main,
    input  logic              clr_mid,
    input  logic [NUM_CH-1:0] clr_ch,
    input  logic              ie_main,
    input  logic              ie_mid,
    input  logic [NUM_CH-1:0] ie_ch,
    input  logic              blk_en,
    input  logic              glb_en,
    output logic [CNT_W-1:0]  count,
    output logic              main_flag,
    output logic              mid_flag,
    output logic [NUM_CH-1:0] ch_flag,
    output logic              irq
);

    localparam int NSRC = NUM_CH + SRC_CH_BASE;

    logic            full_ovf;
    logic            mid_ovf;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] flags;

    tmr_cnt_core #(
        .CNT_W    (CNT_W),
        .MID_BASE (MID_BASE)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .tick       (tick),
        .load_en    (load_en),
        .load_val   (load_val),
        .mid_sel    (mid_sel_e'(mid_sel)),
        .count_o    (count),
        .full_ovf_o (full_ovf),
        .mid_ovf_o  (mid_ovf)
    );

    assign set_vec = {ch_evt, mid_ovf, full_ovf};
    assign clr_vec = {clr_ch, clr_mid, clr_main};
    assign en_vec  = {ie_ch, ie_mid, ie_main};

    tmr_flag_bank #(
        .NSRC (NSRC)
    ) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    tmr_irq_gate #(
        .NSRC (NSRC)
    ) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .en_i    (en_vec),
        .blk_en  (blk_en),
        .glb_en  (glb_en),
        .irq_o   (irq)
    );

    assign main_flag = flags[SRC_MAIN];
    assign mid_flag  = flags[SRC_MID];
    assign ch_flag   = flags[NSRC-1:SRC_CH_BASE];

    AST_MAIN_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        full_ovf |=> main_flag); // R4
    AST_MID_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        mid_ovf |=> mid_flag); // R5
    AST_FLAG_IGNORES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_evt && !glb_en && !blk_en) |=> ((ch_flag & $past(ch_evt)) == $past(ch_evt))); // R7

endmodule

// File: tb/tmr_irq_agg_tb.sv
module tmr_irq_agg_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, tick = 1'b0, load_en = 1'b0;
    logic [15:0] load_val = '0;
    logic [1:0]  mid_sel = '0;
    logic [5:0]  ch_evt = '0, clr_ch = '0, ie_ch = '0;
    logic        clr_main = 1'b0, clr_mid = 1'b0, ie_main = 1'b0, ie_mid = 1'b0;
    logic        blk_en = 1'b0, glb_en = 1'b0;
    logic [15:0] count;
    logic        main_flag, mid_flag, irq;
    logic [5:0]  ch_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .load_en(load_en), .load_val(load_val), .mid_sel(mid_sel),
        .ch_evt(ch_evt), .clr_main(clr_main), .clr_mid(clr_mid), .clr_ch(clr_ch),
        .ie_main(ie_main), .ie_mid(ie_mid), .ie_ch(ie_ch),
        .blk_en(blk_en), .glb_en(glb_en), .count(count),
        .main_flag(main_flag), .mid_flag(mid_flag), .ch_flag(ch_flag), .irq(irq)
    );

    typedef struct packed {
        logic [5:0] evt;
        logic [5:0] en;
        logic       blk;
        logic       glb;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{6'b000001, 6'b000001, 1'b1, 1'b1, 1'b1},
        '{6'b000001, 6'b000000, 1'b1, 1'b1, 1'b0},
        '{6'b100000, 6'b100000, 1'b1, 1'b1, 1'b1},
        '{6'b100000, 6'b011111, 1'b1, 1'b1, 1'b0},
        '{6'b010100, 6'b000100, 1'b1, 1'b1, 1'b1},
        '{6'b111111, 6'b111111, 1'b0, 1'b1, 1'b0},
        '{6'b111111, 6'b111111, 1'b1, 1'b0, 1'b0},
        '{6'b001010, 6'b110101, 1'b1, 1'b1, 1'b0},
        '{6'b001010, 6'b001000, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_main = 1'b1; clr_mid = 1'b1; clr_ch = '1;
        @(negedge clk);
        clr_main = 1'b0; clr_mid = 1'b0; clr_ch = '0;
        @(negedge clk);
    endtask

    // Load a value, then apply exactly one qualified tick.
    task automatic load_tick(input logic [15:0] v);
        load_en = 1'b1; load_val = v;
        @(negedge clk);
        load_en = 1'b0; run_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        run_en = 1'b0; tick = 1'b0;
    endtask

    task automatic mid_case(input logic [1:0] sel, input logic [15:0] v, input logic exp);
        clear_all();
        mid_sel = sel;
        load_tick(v);
        chk($sformatf("R5 sel=%0d val=%0h mid_flag", sel, v), 32'(mid_flag), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", 32'(count), 32'h0);
        chk("R1 reset flags", {mid_flag, main_flag, ch_flag}, 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);

        // Table walk: one channel pattern, enables and gates per row.
        for (int k = 0; k < NVEC; k++) begin
            clear_all();
            ch_evt = TBL[k].evt; ie_ch = TBL[k].en;
            blk_en = TBL[k].blk; glb_en = TBL[k].glb;
            @(negedge clk);
            ch_evt = '0;
            chk($sformatf("R6 R7 row %0d ch_flag", k), 32'(ch_flag), 32'(TBL[k].evt));
            @(negedge clk);
            chk($sformatf("R9 R10 row %0d irq", k), 32'(irq), 32'(TBL[k].exp_irq));
        end
        ie_ch = '0; blk_en = 1'b0; glb_en = 1'b0;
        clear_all();

        // R2: only run_en & tick together advance.
        load_en = 1'b1; load_val = 16'h0000;
        @(negedge clk);
        load_en = 1'b0; run_en = 1'b1; tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 hold tick=0", 32'(count), 32'h0);
        run_en = 1'b0; tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 hold run_en=0", 32'(count), 32'h0);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 advance by 5", 32'(count), 32'h5);

        // R3: load wins over advance.
        load_en = 1'b1; load_val = 16'h1234;
        @(negedge clk);
        chk("R3 load priority", 32'(count), 32'h1234);
        load_val = 16'hFFFF;
        @(negedge clk);
        chk("R3 load FFFF", 32'(count), 32'hFFFF);
        chk("R3 load sets no flag", {mid_flag, main_flag}, 32'h0);
        load_en = 1'b0; run_en = 1'b0; tick = 1'b0;

        // R4: wrap from FFFF.
        mid_sel = 2'd0;
        load_en = 1'b1; load_val = 16'hFFFE;
        @(negedge clk);
        load_en = 1'b0; run_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        chk("R4 at FFFF no flag", {count, 15'h0, main_flag}, {16'hFFFF, 16'h0});
        @(negedge clk);
        run_en = 1'b0; tick = 1'b0;
        chk("R4 wrap count", 32'(count), 32'h0);
        chk("R4 main_flag on wrap", 32'(main_flag), 32'h1);
        chk("R5 mid_flag on wrap", 32'(mid_flag), 32'h1);
        clear_all();
        chk("R8 clear main and mid", {mid_flag, main_flag}, 32'h0);

        // R5: each width select, one case below and one at the carry point.
        mid_case(2'd0, 16'h00FE, 1'b0);
        mid_case(2'd0, 16'h00FF, 1'b1);
        mid_case(2'd1, 16'h00FF, 1'b0);
        mid_case(2'd1, 16'h01FF, 1'b1);
        mid_case(2'd2, 16'h01FF, 1'b0);
        mid_case(2'd2, 16'h03FF, 1'b1);
        mid_case(2'd3, 16'h03FF, 1'b0);
        mid_case(2'd3, 16'h07FF, 1'b1);
        chk("R5 no main flag on mid carry", 32'(main_flag), 32'h0);
        clear_all();

        // R8: set and clear together on a channel flag.
        ch_evt = 6'b000100; clr_ch = 6'b000100;
        @(negedge clk);
        ch_evt = '0; clr_ch = '0;
        chk("R8 set wins channel", 32'(ch_flag), 32'h04);
        clr_ch = 6'b000100;
        @(negedge clk);
        clr_ch = '0;
        chk("R8 clear channel", 32'(ch_flag), 32'h0);

        // R8: wrap tick with main clear in the same cycle.
        load_en = 1'b1; load_val = 16'hFFFF;
        @(negedge clk);
        load_en = 1'b0; run_en = 1'b1; tick = 1'b1; clr_main = 1'b1;
        @(negedge clk);
        run_en = 1'b0; tick = 1'b0; clr_main = 1'b0;
        chk("R8 set wins main", 32'(main_flag), 32'h1);
        clear_all();

        // R9: registered latency, R10: gate drop.
        ie_ch = 6'b000001; blk_en = 1'b1; glb_en = 1'b1;
        @(negedge clk);
        ch_evt = 6'b000001;
        @(negedge clk);
        ch_evt = '0;
        chk("R9 irq not yet with flag", {ch_flag[0], irq}, 32'h2);
        @(negedge clk);
        chk("R9 irq one edge later", 32'(irq), 32'h1);
        glb_en = 1'b0;
        @(negedge clk);
        chk("R10 irq drops on glb_en", 32'(irq), 32'h0);
        chk("R10 flag kept", 32'(ch_flag), 32'h01);
        glb_en = 1'b1; blk_en = 1'b0;
        @(negedge clk);
        chk("R10 irq low on blk_en", 32'(irq), 32'h0);
        blk_en = 1'b1;
        @(negedge clk);
        chk("R9 irq returns", 32'(irq), 32'h1);
        ie_ch = '0;
        @(negedge clk);
        chk("R9 irq off with enable", 32'(irq), 32'h0);
        clear_all();

        // R9: intermediate overflow source through its own enable.
        ie_mid = 1'b1;
        mid_sel = 2'd0;
        load_tick(16'h00FF);
        chk("R9 mid flag set", 32'(mid_flag), 32'h1);
        @(negedge clk);
        chk("R9 irq from mid flag", 32'(irq), 32'h1);
        clr_mid = 1'b1;
        @(negedge clk);
        clr_mid = 1'b0;
        @(negedge clk);
        chk("R9 irq gone after clear", 32'(irq), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule